// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the processor-side register interface of a VGA-style attribute controller. Index and data share one write strobe. An internal phase flag decides what each write does. In index phase a write loads the index register and moves the flag to data phase. In data phase a write stores into the register the index selects and returns the flag to index phase. Software that has lost track of the phase reads the input status port, which forces the flag back to index phase.

The block holds 21 registers. Sixteen 6-bit palette entries sit at selects 0x00–0x0F. Five 8-bit control registers follow: mode at 0x10, overscan colour at 0x11, plane enable at 0x12, horizontal pan at 0x13 and colour select at 0x14. Index bit 5 is the palette-source flag. While it is set the display owns the palette, and processor access to the palette entries is blocked. The flag is exported so that display logic can gate its lookups. The control registers are exported directly.

Top module: `atc_port`

## Requirements
- R1: After reset the phase flag is in index phase (`data_phase_o`=0), the index register is 0, `pal_src_o` is 0 and all 21 registers read 0.
- R2: A write (`attr_wr_i`=1) in index phase loads `attr_wdata_i[5:0]` into the index register, visible on `index_o` after the clock edge, and moves the flag to data phase.
- R3: A write in data phase stores `attr_wdata_i` into the register selected by index bits 4:0 and returns the flag to index phase. The index register is unchanged.
- R4: A cycle with `status_rd_i`=1 leaves the flag in index phase after the edge. A write in the same cycle is still handled according to the phase held before that edge.
- R5: While `data_rd_i`=1, `rdata_o` shows the register selected by the current index in the same cycle. While `data_rd_i`=0, `rdata_o` is 0.
- R6: A data-port read (`data_rd_i`=1 with no write and no status read) does not change the phase flag.
- R7: Palette entries keep only the low 6 bits of a write, and bits 7:6 read as 0.
- R8: While index bit 5 is 1, writes to selects 0x00–0x0F store nothing and reads of them return 0x00. The control registers at 0x10–0x14 stay writable and readable.
- R9: A select of 0x15 or above stores nothing and reads back 0x00.
- R10: `pal_src_o` equals index bit 5 at all times.
- R11: `mode_o`, `overscan_o`, `plane_en_o`, `hpan_o` and `csel_o` show the registers at 0x10, 0x11, 0x12, 0x13 and 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_wr_i | input | 1 | Write strobe for the shared index/data port |
| attr_wdata_i | input | 8 | Write data |
| data_rd_i | input | 1 | Read strobe for the data port |
| status_rd_i | input | 1 | Read strobe of the input status port; clears the phase flag |
| rdata_o | output | 8 | Data-port read value |
| index_o | output | 6 | Index register: palette-source bit and 5-bit select |
| data_phase_o | output | 1 | 1 when the next write goes to a data register |
| pal_src_o | output | 1 | 1 when the display owns the palette |
| mode_o | output | 8 | Mode control register |
| overscan_o | output | 8 | Overscan colour register |
| plane_en_o | output | 8 | Colour plane enable register |
| hpan_o | output | 8 | Horizontal pan register |
| csel_o | output | 8 | Colour select register |

## Verification
Directed pairs of index and data writes cover palette and control selects with the source bit clear. These writes separate correct storage from cross-register aliasing, and they show the truncation of palette data to 6 bits. Writes and reads with the source bit set show that palette access is blocked while control access still works. Selects above 0x14 show that out-of-range accesses are ignored. Status reads placed after a lone index write, and status reads placed in the same cycle as a write, expose errors in the phase flag. A long run of random strobes and data is compared every cycle against a behavioural model and catches ordering faults that the directed cases miss.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned PAL_N   = 16;
  localparam int unsigned PAL_W   = 6;
  localparam int unsigned CTRL_N  = 5;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned REG_N   = PAL_N + CTRL_N;
  // control register order as seen from the select field
  localparam int unsigned C_MODE  = 0;
  localparam int unsigned C_OVSC  = 1;
  localparam int unsigned C_PLANE = 2;
  localparam int unsigned C_HPAN  = 3;
  localparam int unsigned C_CSEL  = 4;
endpackage

// File: rtl/atc_flipflop.sv
module atc_flipflop #(
  parameter int unsigned SEL_W = atc_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W:0]   wr_data_i,
  input  logic             status_rd_i,
  input  logic             data_rd_i,
  output logic             data_phase_o,
  output logic [SEL_W:0]   index_o,
  output logic             data_wr_o
);
  logic           phase_q;
  logic [SEL_W:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (wr_i && !phase_q) idx_q <= wr_data_i;
      if (status_rd_i)      phase_q <= 1'b0;
      else if (wr_i)        phase_q <= ~phase_q;
    end
  end

  assign data_phase_o = phase_q;
  assign index_o      = idx_q;
  assign data_wr_o    = wr_i && phase_q;

  a_r4_status_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !data_phase_o);
  a_r2_index_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !data_phase_o && !status_rd_i) |=> (data_phase_o && index_o == $past(wr_data_i)));
  a_r3_data_then_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_phase_o) |=> (!data_phase_o && $stable(index_o)));
  a_r6_read_keeps_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !wr_i && !status_rd_i) |=> $stable(data_phase_o));
endmodule

// File: rtl/atc_regbank.sv
module atc_regbank #(
  parameter int unsigned DW     = atc_pkg::DW,
  parameter int unsigned PAL_N  = atc_pkg::PAL_N,
  parameter int unsigned PAL_W  = atc_pkg::PAL_W,
  parameter int unsigned CTRL_N = atc_pkg::CTRL_N,
  parameter int unsigned SEL_W  = atc_pkg::SEL_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic                           pal_src_i,
  input  logic [DW-1:0]                  wd_i,
  output logic [PAL_N-1:0][PAL_W-1:0]    pal_o,
  output logic [CTRL_N-1:0][DW-1:0]      ctrl_o
);
  for (genvar i = 0; i < PAL_N; i++) begin : g_pal
    logic             en;
    logic [PAL_W-1:0] q;
    assign en = we_i && !pal_src_i && (sel_i == SEL_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= wd_i[PAL_W-1:0];
    end
    assign pal_o[i] = q;

    a_r8_pal_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && pal_src_i && sel_i == SEL_W'(i)) |=> $stable(pal_o[i]));
  end

  for (genvar j = 0; j < CTRL_N; j++) begin : g_ctrl
    logic          en;
    logic [DW-1:0] q;
    assign en = we_i && (sel_i == SEL_W'(PAL_N + j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= wd_i;
    end
    assign ctrl_o[j] = q;
  end
endmodule

// File: rtl/atc_rdmux.sv
module atc_rdmux #(
  parameter int unsigned DW     = atc_pkg::DW,
  parameter int unsigned PAL_N  = atc_pkg::PAL_N,
  parameter int unsigned PAL_W  = atc_pkg::PAL_W,
  parameter int unsigned CTRL_N = atc_pkg::CTRL_N,
  parameter int unsigned SEL_W  = atc_pkg::SEL_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic                         pal_src_i,
  input  logic [PAL_N-1:0][PAL_W-1:0]  pal_i,
  input  logic [CTRL_N-1:0][DW-1:0]    ctrl_i,
  output logic [DW-1:0]                rd_data_o
);
  localparam int unsigned PW = $clog2(PAL_N);
  localparam int unsigned CW = (CTRL_N > 1) ? $clog2(CTRL_N) : 1;

  logic          is_pal, is_ctrl;
  logic [CW-1:0] cidx;

  assign is_pal  = sel_i < SEL_W'(PAL_N);
  assign is_ctrl = !is_pal && (sel_i < SEL_W'(PAL_N + CTRL_N));
  assign cidx    = CW'(sel_i - SEL_W'(PAL_N));

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (is_pal && !pal_src_i) rd_data_o = DW'(pal_i[sel_i[PW-1:0]]);
      else if (is_ctrl)         rd_data_o = ctrl_i[cidx];
    end
  end

  a_r7_pal_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_pal) |-> rd_data_o[DW-1:PAL_W] == '0);
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);
endmodule

// File: rtl/atc_port.sv
module atc_port #(
  parameter int unsigned DW     = atc_pkg::DW,
  parameter int unsigned PAL_N  = atc_pkg::PAL_N,
  parameter int unsigned PAL_W  = atc_pkg::PAL_W,
  parameter int unsigned CTRL_N = atc_pkg::CTRL_N,
  parameter int unsigned SEL_W  = atc_pkg::SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            attr_wr_i,
  input  logic [DW-1:0]   attr_wdata_i,
  input  logic            data_rd_i,
  input  logic            status_rd_i,
  output logic [DW-1:0]   rdata_o,
  output logic [SEL_W:0]  index_o,
  output logic            data_phase_o,
  output logic            pal_src_o,
  output logic [DW-1:0]   mode_o,
  output logic [DW-1:0]   overscan_o,
  output logic [DW-1:0]   plane_en_o,
  output logic [DW-1:0]   hpan_o,
  output logic [DW-1:0]   csel_o
);
  import atc_pkg::*;

  logic                        data_wr;
  logic [SEL_W:0]              idx;
  logic [PAL_N-1:0][PAL_W-1:0] pal;
  logic [CTRL_N-1:0][DW-1:0]   ctrl;

  atc_flipflop #(.SEL_W(SEL_W)) u_ff (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(attr_wr_i),
    .wr_data_i(attr_wdata_i[SEL_W:0]), .status_rd_i(status_rd_i),
    .data_rd_i(data_rd_i), .data_phase_o(data_phase_o),
    .index_o(idx), .data_wr_o(data_wr)
  );

  atc_regbank #(.DW(DW), .PAL_N(PAL_N), .PAL_W(PAL_W), .CTRL_N(CTRL_N), .SEL_W(SEL_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(data_wr), .sel_i(idx[SEL_W-1:0]),
    .pal_src_i(idx[SEL_W]), .wd_i(attr_wdata_i), .pal_o(pal), .ctrl_o(ctrl)
  );

  atc_rdmux #(.DW(DW), .PAL_N(PAL_N), .PAL_W(PAL_W), .CTRL_N(CTRL_N), .SEL_W(SEL_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(data_rd_i), .sel_i(idx[SEL_W-1:0]),
    .pal_src_i(idx[SEL_W]), .pal_i(pal), .ctrl_i(ctrl), .rd_data_o(rdata_o)
  );

  assign index_o    = idx;
  assign pal_src_o  = idx[SEL_W];
  assign mode_o     = ctrl[C_MODE];
  assign overscan_o = ctrl[C_OVSC];
  assign plane_en_o = ctrl[C_PLANE];
  assign hpan_o     = ctrl[C_HPAN];
  assign csel_o     = ctrl[C_CSEL];

  a_r10_src_follows_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_wr_i && !data_phase_o) |=> pal_src_o == $past(attr_wdata_i[SEL_W]));
endmodule

// File: tb/atc_port_tb.sv
module atc_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, st = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, mode, ovsc, plane, hpan, csel;
  logic [5:0] index;
  logic       phase, src;

  int tests = 0, fails = 0;
  int m_reg [21];
  int m_idx = 0;
  bit m_ph = 0;

  always #2 clk = ~clk;

  atc_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .attr_wr_i(wr), .attr_wdata_i(wd),
    .data_rd_i(rd), .status_rd_i(st), .rdata_o(rdata), .index_o(index),
    .data_phase_o(phase), .pal_src_o(src), .mode_o(mode), .overscan_o(ovsc),
    .plane_en_o(plane), .hpan_o(hpan), .csel_o(csel)
  );

  function automatic int exp_rd();
    int s = m_idx & 31;
    if (!rd) return 0;
    if (s < 16) return (m_idx & 32) ? 0 : m_reg[s];
    if (s < 21) return m_reg[s];
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5/R7/R8/R9 rdata", rdata, exp_rd());
    chk("R2/R3 index", index, m_idx);
    chk("R4/R6 phase", phase, m_ph);
    chk("R10 pal_src", src, (m_idx >> 5) & 1);
    chk("R11 mode", mode, m_reg[16]);
    chk("R11 overscan", ovsc, m_reg[17]);
    chk("R11 plane", plane, m_reg[18]);
    chk("R11 hpan", hpan, m_reg[19]);
    chk("R11 csel", csel, m_reg[20]);
  endtask

  task automatic model_edge();
    if (wr) begin
      if (!m_ph) m_idx = wd & 8'h3f;
      else begin
        int s = m_idx & 31;
        if (s < 16) begin
          if (!(m_idx & 32)) m_reg[s] = wd & 8'h3f;
        end else if (s < 21) m_reg[s] = wd;
      end
    end
    if (st) m_ph = 0;
    else if (wr) m_ph = !m_ph;
  endtask

  task automatic cyc(bit w, int d, bit r, bit s);
    @(negedge clk);
    wr = w; wd = 8'(d); rd = r; st = s;
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic put(int i, int d);
    cyc(1, i, 0, 0);
    cyc(1, d, 0, 0);
  endtask

  task automatic peek(int i, int exp, string tag);
    cyc(1, i, 0, 0);
    cyc(0, 0, 1, 0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (m_reg[k]) m_reg[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 phase", phase, 0);
    chk("R1 index", index, 0);
    chk("R1 src", src, 0);
    for (int k = 0; k < 21; k++) begin
      cyc(1, k, 0, 0);
      cyc(0, 0, 1, 0);
      chk("R1 reg zero", rdata, 0);
      cyc(0, 0, 0, 1);
    end
    // R2/R3/R11 control writes
    put(16, 8'h41); put(17, 8'h5a); put(18, 8'h0f); put(19, 8'h08); put(20, 8'hc3);
    chk("R11 mode value", mode, 8'h41);
    chk("R11 csel value", csel, 8'hc3);
    // R7 palette truncation
    put(3, 8'hff);
    peek(3, 8'h3f, "R7 palette 6-bit");
    cyc(0, 0, 0, 1);
    put(15, 8'h2a);
    peek(15, 8'h2a, "R3 palette store");
    cyc(0, 0, 0, 1);
    // R8 source bit blocks palette, not control
    put(8'h23, 8'h12);
    peek(8'h23, 0, "R8 blocked read");
    cyc(0, 0, 0, 1);
    chk("R10 src set", src, 1);
    put(8'h34, 8'h99);
    chk("R8 control with src", csel, 8'h99);
    peek(8'h03, 8'h3f, "R8 write was blocked");
    cyc(0, 0, 0, 1);
    // R9 out of range
    put(8'h17, 8'h77);
    peek(8'h17, 0, "R9 out of range");
    cyc(0, 0, 0, 1);
    // R4 status after lone index write
    cyc(1, 5, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R4 phase cleared", phase, 0);
    cyc(1, 16, 0, 0);
    chk("R4 next write is index", index, 16);
    // R6 data reads keep phase
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R6 phase held", phase, 1);
    // R4 status with data write same cycle
    cyc(1, 8'h66, 0, 1);
    chk("R4 same-cycle write stored", mode, 8'h66);
    chk("R4 same-cycle phase", phase, 0);
    cyc(1, 2, 0, 1);
    chk("R4 index write then cleared", index, 2);
    // random run against model
    for (int n = 0; n < 2000; n++)
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
          1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule